// File: doc/BRIEF.md
# Two-Level Round-Robin Bus Arbiter

This block decides which of five bus masters may start the next transaction on a shared bus. Each master carries a configuration bit that puts it in a high-priority tier or a low-priority tier. High-tier masters take turns round-robin. The low tier as a whole fills one extra turn at the end of each high-tier pass, and a separate round-robin pointer picks which low-tier master uses that turn.

The grant vector is registered and carries at most one bit. The grant is worked out again on every cycle from the current requests. A grant that has not yet been used can therefore be taken away when a master that is ahead in the rotation starts requesting. The rotation moves forward only when the granted master actually begins its transaction on an idle bus. The master on the highest index is normally the internal host controller, but the arbiter treats all five in the same way.

Top module: `tier_rr_arbiter`

## Requirements
- R1: While rst_ni is low, gnt_o is zero. After reset the rotation pointers restart, so the first grant goes to the lowest-index requesting high-tier master, or to the lowest-index requesting low-tier master when no high-tier master requests.
- R2: gnt_o has at most one bit set. A bit set on gnt_o belongs to a master whose req_i bit was high at the previous clock edge. The grant appears one clock after the requests it is based on.
- R3: High-tier masters (hi_grp_i bit = 1) are served in ascending index order, wrapping around, one grant each per pass.
- R4: The low tier (hi_grp_i bit = 0) takes one turn after the last high-tier position of each pass. Each time that turn is used, the next requesting low-tier master in ascending wrapped order is served. With masters 0 and 1 high and masters 2, 3 and 4 low, all requesting, the order is 0,1,2,0,1,3,0,1,4 and then repeats.
- R5: Masters that are not requesting are skipped in both tiers. In the R4 setup with master 1 idle, the order is 0,2,0,3,0,4.
- R6: With h requesting high-tier masters and l ≥ 1 requesting low-tier masters, every span of (h+1)·l consecutive used grants from reset gives each high-tier requester l grants and each low-tier requester one grant.
- R7: When all requesters are in one tier, they are served in plain round-robin, each once per span equal to the number of requesters.
- R8: A grant that has not been used is recomputed on every cycle. Suppose a low-tier master holds the pending grant and a high-tier master that comes earlier in the current pass starts requesting. The grant then moves to that high-tier master on the next clock edge.
- R9: A grant is used, and the rotation advances, only at a clock edge where start_i and bus_idle_i are both high while gnt_o is nonzero. A grant that is revoked, or a start while the bus is busy, leaves the rotation where it was.
- R10: When no master requests, gnt_o becomes zero on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 5 | Bus request, one bit per master |
| hi_grp_i | input | 5 | Tier select per master: 1 = high tier, 0 = low tier |
| bus_idle_i | input | 1 | The bus has no transaction in progress |
| start_i | input | 1 | The granted master starts its transaction in this cycle |
| gnt_o | output | 5 | Registered grant, at most one bit set |

## Verification
The sweep goes through all 32 tier settings combined with all 31 non-empty request patterns. For each pair it counts the grants over two full rotation spans and compares each master's share with the (h+1)·l formula. This separates correct tier slotting from a flat round-robin and from a low tier that steals extra turns. Two fixed settings check the exact order of grants, which a fairness count alone would not catch. A directed sequence then adds a late high-tier request on top of a pending low-tier grant, and after that a start on a busy bus. Together these show that the grant is revoked and that the rotation pointers stay put until a grant is really used.

// File: rtl/tier_arb_pkg.sv
package tier_arb_pkg;
  function automatic int wrap_add(input int a, input int b, input int m);
    int s;
    s = a + b;
    return (s >= m) ? s - m : s;
  endfunction
endpackage

// File: rtl/rr_pick.sv
module rr_pick
  import tier_arb_pkg::*;
#(
  parameter int W  = 6,
  parameter int PW = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  input  logic [PW-1:0] ptr_i,
  output logic          valid_o,
  output logic [PW-1:0] idx_o
);
  // descending scan: last hit written is the nearest at or after ptr
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    for (int k = W - 1; k >= 0; k--) begin
      int p;
      p = wrap_add(int'(ptr_i), k, W);
      if (vec_i[p]) begin
        valid_o = 1'b1;
        idx_o   = PW'(p);
      end
    end
  end
endmodule

// File: rtl/tier_state.sv
module tier_state
  import tier_arb_pkg::*;
#(
  parameter int N   = 5,
  parameter int HPW = $clog2(N + 1),
  parameter int LPW = $clog2(N)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           used_i,
  input  logic           via_lo_i,
  input  logic [LPW-1:0] idx_i,
  output logic [HPW-1:0] hi_ptr_o,
  output logic [LPW-1:0] lo_ptr_o
);
  logic [HPW-1:0] hi_ptr_q;
  logic [LPW-1:0] lo_ptr_q;

  // next pointers are exported so the pick in this cycle already sees the advance
  always_comb begin
    hi_ptr_o = hi_ptr_q;
    lo_ptr_o = lo_ptr_q;
    if (used_i) begin
      if (via_lo_i) begin
        hi_ptr_o = '0;
        lo_ptr_o = LPW'(wrap_add(int'(idx_i), 1, N));
      end else begin
        hi_ptr_o = HPW'(int'(idx_i) + 1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_ptr_q <= '0;
      lo_ptr_q <= '0;
    end else begin
      hi_ptr_q <= hi_ptr_o;
      lo_ptr_q <= lo_ptr_o;
    end
  end

  p_ptr_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !used_i |=> ($stable(hi_ptr_q) && $stable(lo_ptr_q)));
endmodule

// File: rtl/tier_rr_arbiter.sv
module tier_rr_arbiter #(
  parameter int N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] hi_grp_i,
  input  logic         bus_idle_i,
  input  logic         start_i,
  output logic [N-1:0] gnt_o
);
  localparam int HW  = N + 1;  // high positions plus one low-tier slot
  localparam int HPW = $clog2(HW);
  localparam int LPW = $clog2(N);

  logic [N-1:0]   gnt_q, gnt_d;
  logic           via_lo_q, via_lo_d;
  logic [HW-1:0]  hi_vec;
  logic [N-1:0]   lo_vec;
  logic [LPW-1:0] gnt_idx;
  logic           used;
  logic [HPW-1:0] hi_ptr, hi_idx;
  logic [LPW-1:0] lo_ptr, lo_idx;
  logic           hi_v, lo_v;

  assign lo_vec = req_i & ~hi_grp_i;

  for (genvar i = 0; i < N; i++) begin : g_hi
    assign hi_vec[i] = req_i[i] & hi_grp_i[i];
  end
  assign hi_vec[N] = |lo_vec;

  always_comb begin
    gnt_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (gnt_q[i]) gnt_idx = LPW'(i);
    end
  end

  assign used = start_i & bus_idle_i & (|gnt_q);

  tier_state #(.N(N), .HPW(HPW), .LPW(LPW)) u_state (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .used_i   (used),
    .via_lo_i (via_lo_q),
    .idx_i    (gnt_idx),
    .hi_ptr_o (hi_ptr),
    .lo_ptr_o (lo_ptr)
  );

  rr_pick #(.W(HW), .PW(HPW)) u_hi_pick (
    .vec_i   (hi_vec),
    .ptr_i   (hi_ptr),
    .valid_o (hi_v),
    .idx_o   (hi_idx)
  );

  rr_pick #(.W(N), .PW(LPW)) u_lo_pick (
    .vec_i   (lo_vec),
    .ptr_i   (lo_ptr),
    .valid_o (lo_v),
    .idx_o   (lo_idx)
  );

  always_comb begin
    gnt_d    = '0;
    via_lo_d = 1'b0;
    if (hi_v) begin
      if (int'(hi_idx) == N) begin
        gnt_d[lo_idx] = lo_v;
        via_lo_d      = 1'b1;
      end else begin
        gnt_d[LPW'(hi_idx)] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gnt_q    <= '0;
      via_lo_q <= 1'b0;
    end else begin
      gnt_q    <= gnt_d;
      via_lo_q <= via_lo_d;
    end
  end

  assign gnt_o = gnt_q;

  p_gnt_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));
  p_gnt_to_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|gnt_o) |-> (|(gnt_o & $past(req_i))));
  p_idle_no_gnt_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i == '0) |=> (gnt_o == '0));
  p_lo_tier_gnt_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(gnt_o & ~$past(hi_grp_i))) |-> (|$past(req_i & ~hi_grp_i)));
endmodule

// File: tb/tier_rr_arbiter_test.sv
module tier_rr_arbiter_test;
  localparam int N      = 5;
  localparam int CLK_NS = 10;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [N-1:0] req = '0;
  logic [N-1:0] hig = '0;
  logic         idle = 1'b1;
  logic         start = 1'b1;
  logic [N-1:0] gnt;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  tier_rr_arbiter #(.N(N)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .hi_grp_i(hig),
    .bus_idle_i(idle), .start_i(start), .gnt_o(gnt)
  );

  always #(CLK_NS/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int idx_of(input logic [N-1:0] g);
    int r = -1;
    for (int i = 0; i < N; i++) if (g[i]) r = i;
    return r;
  endfunction

  task automatic restart(input logic [N-1:0] r, input logic [N-1:0] h);
    @(negedge clk);
    rst_ni = 1'b0; req = r; hig = h; idle = 1'b1; start = 1'b1;
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_NS * 190000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int seq_a[9] = '{0, 1, 2, 0, 1, 3, 0, 1, 4};
    int seq_b[6] = '{0, 2, 0, 3, 0, 4};

    // R1: reset state
    req = 5'b11111; hig = 5'b00011;
    repeat (2) @(negedge clk);
    chk("R1 grant in reset", int'(gnt), 0);

    // R4 exact order
    restart(5'b11111, 5'b00011);
    for (int s = 0; s < 9; s++) begin
      chk("R4 order", idx_of(gnt), seq_a[s]);
      @(negedge clk);
    end
    // R5 skip idle master
    restart(5'b11101, 5'b00011);
    for (int s = 0; s < 6; s++) begin
      chk("R5 skip order", idx_of(gnt), seq_b[s]);
      @(negedge clk);
    end
    // R1 first grant goes to a low master when no high requests
    restart(5'b01100, 5'b00011);
    chk("R1 first low", idx_of(gnt), 2);

    // R3 R6 R7 sweep
    for (int c = 0; c < 32; c++) begin
      for (int r = 1; r < 32; r++) begin
        int h, l, span, cnt[N];
        int bad;
        h = $countones(5'(r) & 5'(c));
        l = $countones(5'(r) & ~5'(c));
        span = (l > 0) ? (h + 1) * l : h;
        for (int i = 0; i < N; i++) cnt[i] = 0;
        bad = 0;
        restart(5'(r), 5'(c));
        for (int s = 0; s < 2 * span; s++) begin
          if (!$onehot(gnt) || ((gnt & 5'(r)) == '0)) bad++;
          else cnt[idx_of(gnt)]++;
          @(negedge clk);
        end
        chk("R2 onehot to requester", bad, 0);
        for (int i = 0; i < N; i++) begin
          int e;
          if (!r[i]) e = 0;
          else if (c[i]) e = (l > 0) ? 2 * l : 2;
          else e = 2;
          if (h == 0 || l == 0) chk("R7 flat share", cnt[i], e);
          else if (c[i]) chk("R3 R6 high share", cnt[i], e);
          else chk("R6 low share", cnt[i], e);
        end
      end
    end

    // R8 revoke pending low grant
    restart(5'b11101, 5'b00011);
    chk("R8 first", idx_of(gnt), 0);
    @(negedge clk);
    chk("R8 pending low", idx_of(gnt), 2);
    start = 1'b0; req = 5'b11111;
    @(negedge clk);
    chk("R8 revoked to high", idx_of(gnt), 1);
    // R9 start on busy bus ignored
    idle = 1'b0; start = 1'b1;
    @(negedge clk);
    chk("R9 busy start ignored", idx_of(gnt), 1);
    idle = 1'b1;
    @(negedge clk);
    chk("R9 low pointer kept", idx_of(gnt), 2);
    @(negedge clk);
    chk("R9 wrap to first high", idx_of(gnt), 0);

    // R10 no request
    req = '0;
    @(negedge clk);
    chk("R10 no grant", int'(gnt), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule